// File: doc/BRIEF.md
# Auto-Ranging Clock Prescaler

This block runs on a master clock whose frequency is not configured. It counts master-clock cycles between successive rising edges of an 8 kHz frame sync. It matches that count against seven legal frame lengths and locks onto a rate once two frames in a row agree. From the locked frame length it makes two ticks that do not depend on the master-clock rate: a 256 kHz tick, 32 per frame, and an 8 kHz tick, one per frame. A phase accumulator spreads the 32 fast ticks evenly, including at the non-integer 193-cycle frame.

The same block owns the power state. Standby is entered in either of two cases: the power-up input is low, or frame sync stays low for longer than a whole frame while the clock keeps running. Leaving standby needs the power-up input high and frame-sync pulses present. The transmit-output enable is held off for two further frame-sync periods before the serial transmitter may drive its pin. Frame sync and the power-up input are asynchronous. Each passes through a two-stage synchronizer, and the logic acts on a sampled edge at the second clock edge after the edge that samples it.

Top module: `autorange_prescaler`

## Requirements
- R1: The frame length is the number of clock cycles from one synchronized frame-sync rising edge to the next. A length equal to 32, 64, 192, 193, 256, 320 or 512 selects rate index 0, 1, 2, 3, 4, 5 or 6. An exact match takes priority over a match within one cycle, and the lowest index wins among near matches (191 gives index 2, 194 gives index 3, 257 gives index 4).
- R2: `rate_idx` and `locked` change only at a frame-sync rising edge. A new index is adopted, with `locked` set, only when the current and the previous measurements both select that same index, so a single differing frame leaves the rate unchanged.
- R3: A measured length that matches no rate clears `locked` at that edge and leaves `rate_idx` unchanged.
- R4: While running, `tick_256k` pulses once on the clock cycle after each frame-sync rising edge is acted on. Across a full frame of the locked length it pulses exactly 32 times.
- R5: While running, `tick_8k` pulses exactly once per frame, on the same cycle as the frame-aligned `tick_256k` pulse.
- R6: Both ticks stay low while the block is unlocked or in standby. Running means locked and not in standby.
- R7: If synchronized frame sync stays low for at least the locked frame length plus 2 cycles (514 cycles when unlocked), the block enters standby: `standby` high, `tx_oe` low.
- R8: A synchronized low on `pwr_up_in` forces standby with `tx_oe` low on the next cycle, whatever frame sync does.
- R9: With `pwr_up_in` high, the first frame-sync rising edge ends standby. `tx_oe` goes high only at the second further rising edge after that one.
- R10: The first frame-sync rising edge after reset produces no measurement, so `locked` cannot be set before the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync_in | input | 1 | Asynchronous 8 kHz frame sync |
| pwr_up_in | input | 1 | Asynchronous power-up request, high to operate |
| tick_256k | output | 1 | One-cycle 256 kHz tick, 32 per frame |
| tick_8k | output | 1 | One-cycle sample tick, one per frame |
| locked | output | 1 | A confirmed legal rate is in use |
| rate_idx | output | 3 | Index of the selected rate (see R1) |
| standby | output | 1 | Low-power state is active |
| tx_oe | output | 1 | Transmit output may be driven |

## Verification
A wrong classification or a broken confirmation filter shows up on `rate_idx` and `locked` at the rising edge that completes the affected frame, about two clocks after the pulse reaches the pins. An accumulator error shows up as a fast tick on the wrong cycle within the same frame, and as a wrong tick count by the end of that frame. A fault in the power-state sequencing moves the rise of `tx_oe` by whole frames, so an off-by-one in the wake count appears one frame early or late. Because the reference model is compared on every cycle, the first cycle where any of these diverge is reported.

// File: rtl/arp_pkg.sv
`timescale 1ns/1ps
package arp_pkg;
  localparam int NUM_RATES   = 7;
  localparam int RATE_W      = 3;
  localparam int MAX_FRAME   = 512;
  localparam int LOSS_MARGIN = 2;

  typedef struct packed {
    logic              ok;
    logic [RATE_W-1:0] idx;
  } rate_match_t;

  typedef enum logic [1:0] {
    PS_OFF  = 2'd0,
    PS_WAKE = 2'd1,
    PS_ON   = 2'd2
  } pwr_state_t;

  // Master-clock cycles per frame for each rate index.
  function automatic int unsigned nominal_len(input logic [RATE_W-1:0] idx);
    case (idx)
      3'd0:    return 32;
      3'd1:    return 64;
      3'd2:    return 192;
      3'd3:    return 193;
      3'd4:    return 256;
      3'd5:    return 320;
      default: return MAX_FRAME;
    endcase
  endfunction

  // Exact match first; otherwise the lowest index within one cycle.
  function automatic rate_match_t classify(input int unsigned period);
    rate_match_t r;
    r = '0;
    for (int i = 0; i < NUM_RATES; i++)
      if (period == nominal_len(RATE_W'(i))) begin
        r.ok  = 1'b1;
        r.idx = RATE_W'(i);
      end
    if (!r.ok)
      for (int i = NUM_RATES - 1; i >= 0; i--)
        if ((period + 1 == nominal_len(RATE_W'(i))) ||
            (period == nominal_len(RATE_W'(i)) + 1)) begin
          r.ok  = 1'b1;
          r.idx = RATE_W'(i);
        end
    return r;
  endfunction
endpackage

// File: rtl/arp_sync.sv
`timescale 1ns/1ps
module arp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic lvl,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= STAGES'({chain, d});
      last  <= chain[STAGES-1];
    end
  end

  assign lvl  = chain[STAGES-1];
  assign rise = chain[STAGES-1] & ~last;
endmodule

// File: rtl/arp_meter.sv
`timescale 1ns/1ps
module arp_meter
  import arp_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fs_rise,
  output logic              locked,
  output logic [RATE_W-1:0] rate_idx
);
  logic [CNT_W-1:0]  cnt;
  logic              have_ref;
  logic              prev_ok;
  logic [RATE_W-1:0] prev_idx;
  rate_match_t       cur;
  logic              measure;
  logic              confirm;

  assign cur     = classify(32'(cnt));
  assign measure = fs_rise & have_ref;
  assign confirm = measure & cur.ok & prev_ok & (prev_idx == cur.idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      have_ref <= 1'b0;
      prev_ok  <= 1'b0;
      prev_idx <= '0;
      locked   <= 1'b0;
      rate_idx <= '0;
    end else begin
      if (fs_rise)       cnt <= CNT_W'(1);
      else if (~&cnt)    cnt <= cnt + CNT_W'(1);
      have_ref <= have_ref | fs_rise;
      if (measure) begin
        prev_ok  <= cur.ok;
        prev_idx <= cur.idx;
        if (!cur.ok) begin
          locked <= 1'b0;
        end else if (confirm) begin
          locked   <= 1'b1;
          rate_idx <= cur.idx;
        end
      end
    end
  end

  AST_RATE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_rise |=> ($stable(rate_idx) && $stable(locked))); // R2
  AST_BAD_PERIOD_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (measure && !cur.ok) |=> (!locked && $stable(rate_idx))); // R3
  AST_FIRST_RISE_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_rise && !have_ref) |=> !locked); // R10
endmodule

// File: rtl/arp_tickgen.sv
`timescale 1ns/1ps
module arp_tickgen #(
  parameter int CNT_W = 10,
  parameter int STEP  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             fs_rise,
  input  logic [CNT_W-1:0] frame_len,
  output logic             tick_fast,
  output logic             tick_frame
);
  logic [CNT_W-1:0] acc;
  logic [CNT_W:0]   sum;
  logic             wrap;

  assign sum  = {1'b0, acc} + (CNT_W+1)'(STEP);
  assign wrap = (sum >= {1'b0, frame_len});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc        <= '0;
      tick_fast  <= 1'b0;
      tick_frame <= 1'b0;
    end else if (!run) begin
      acc        <= '0;
      tick_fast  <= 1'b0;
      tick_frame <= 1'b0;
    end else if (fs_rise) begin
      acc        <= '0;
      tick_fast  <= 1'b1;
      tick_frame <= 1'b1;
    end else begin
      tick_frame <= 1'b0;
      tick_fast  <= wrap;
      acc        <= wrap ? CNT_W'(sum - {1'b0, frame_len}) : sum[CNT_W-1:0];
    end
  end

  AST_ACC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (acc < frame_len)); // R4
  AST_FRAME_TICK_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_frame |-> ($past(fs_rise) && tick_fast)); // R5
endmodule

// File: rtl/arp_power.sv
`timescale 1ns/1ps
module arp_power
  import arp_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int WAKE_FRAMES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pu_lvl,
  input  logic             fs_lvl,
  input  logic             fs_rise,
  input  logic [CNT_W-1:0] loss_limit,
  output logic             standby,
  output logic             tx_oe,
  output logic             active
);
  localparam int WK_W = $clog2(WAKE_FRAMES + 1);

  pwr_state_t       st;
  logic [WK_W-1:0]  wk;
  logic [CNT_W-1:0] low_run;
  logic             loss;

  assign loss = (low_run >= loss_limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run <= '0;
    end else if (fs_lvl) begin
      low_run <= '0;
    end else if (~&low_run) begin
      low_run <= low_run + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= PS_OFF;
      wk <= '0;
    end else if (!pu_lvl) begin
      st <= PS_OFF;
      wk <= '0;
    end else begin
      case (st)
        PS_OFF: if (fs_rise) begin
          st <= PS_WAKE;
          wk <= '0;
        end
        PS_WAKE: if (loss) begin
          st <= PS_OFF;
        end else if (fs_rise) begin
          if (wk == WK_W'(WAKE_FRAMES - 1)) st <= PS_ON;
          else                              wk <= wk + WK_W'(1);
        end
        PS_ON: if (loss) st <= PS_OFF;
        default: st <= PS_OFF;
      endcase
    end
  end

  assign standby = (st == PS_OFF);
  assign tx_oe   = (st == PS_ON);
  assign active  = (st != PS_OFF);

  AST_PWR_DOWN_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !pu_lvl |=> (standby && !tx_oe)); // R8
  AST_LOSS_DROPS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    loss |=> !tx_oe); // R7
  AST_OE_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_oe) |-> $past(fs_rise)); // R9
endmodule

// File: rtl/autorange_prescaler.sv
`timescale 1ns/1ps
module autorange_prescaler
  import arp_pkg::*;
#(
  parameter int CNT_W           = 10,
  parameter int SYNC_STAGES     = 2,
  parameter int WAKE_FRAMES     = 2,
  parameter int TICKS_PER_FRAME = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fsync_in,
  input  logic       pwr_up_in,
  output logic       tick_256k,
  output logic       tick_8k,
  output logic       locked,
  output logic [2:0] rate_idx,
  output logic       standby,
  output logic       tx_oe
);
  localparam logic [CNT_W-1:0] UNLOCKED_LIMIT = CNT_W'(MAX_FRAME + LOSS_MARGIN);

  logic             fs_lvl, fs_rise, pu_lvl, pu_rise_unused;
  logic             active, run;
  logic [CNT_W-1:0] frame_len, loss_limit;

  arp_sync #(.STAGES(SYNC_STAGES)) u_fs_sync (
    .clk(clk), .rst_n(rst_n), .d(fsync_in), .lvl(fs_lvl), .rise(fs_rise));
  arp_sync #(.STAGES(SYNC_STAGES)) u_pu_sync (
    .clk(clk), .rst_n(rst_n), .d(pwr_up_in), .lvl(pu_lvl), .rise(pu_rise_unused));

  arp_meter #(.CNT_W(CNT_W)) u_meter (
    .clk(clk), .rst_n(rst_n), .fs_rise(fs_rise), .locked(locked), .rate_idx(rate_idx));

  assign frame_len  = CNT_W'(nominal_len(rate_idx));
  assign loss_limit = locked ? (frame_len + CNT_W'(LOSS_MARGIN)) : UNLOCKED_LIMIT;
  assign run        = locked & active;

  arp_tickgen #(.CNT_W(CNT_W), .STEP(TICKS_PER_FRAME)) u_tickgen (
    .clk(clk), .rst_n(rst_n), .run(run), .fs_rise(fs_rise), .frame_len(frame_len),
    .tick_fast(tick_256k), .tick_frame(tick_8k));

  arp_power #(.CNT_W(CNT_W), .WAKE_FRAMES(WAKE_FRAMES)) u_power (
    .clk(clk), .rst_n(rst_n), .pu_lvl(pu_lvl), .fs_lvl(fs_lvl), .fs_rise(fs_rise),
    .loss_limit(loss_limit), .standby(standby), .tx_oe(tx_oe), .active(active));

  AST_NO_TICK_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked || standby) |=> (!tick_256k && !tick_8k)); // R6
  AST_OE_IMPLIES_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_oe |-> !standby); // R9
endmodule

// File: tb/autorange_prescaler_bench.sv
`timescale 1ns/1ps
module autorange_prescaler_bench;
  logic       clk = 1'b0;
  logic       rst_n, fsync_in, pwr_up_in;
  logic       tick_256k, tick_8k, locked, standby, tx_oe;
  logic [2:0] rate_idx;

  always #2 clk = ~clk;

  autorange_prescaler u_autorange_prescaler (
    .clk(clk), .rst_n(rst_n), .fsync_in(fsync_in), .pwr_up_in(pwr_up_in),
    .tick_256k(tick_256k), .tick_8k(tick_8k), .locked(locked),
    .rate_idx(rate_idx), .standby(standby), .tx_oe(tx_oe));

  int n_checks = 0, n_fail = 0, n_cyc = 0;
  int seen_fast, seen_frame;
  int legal[7] = '{32, 64, 192, 193, 256, 320, 512};

  // Reference model state
  int fq[$], pq[$];
  int m_cnt, m_have, m_pok, m_pidx, m_lock, m_rate, m_acc, m_t256, m_t8, m_low, m_st, m_wk;

  task automatic chk(input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", what, act, exp, n_cyc);
    end
  endtask

  function automatic int pick_rate(input int p);
    int best = -1;
    foreach (legal[i]) if (p == legal[i]) best = i;
    if (best >= 0) return best;
    foreach (legal[i]) begin
      int d = p - legal[i];
      if (best < 0 && (d == 1 || d == -1)) best = i;
    end
    return best;
  endfunction

  task automatic model_clear();
    fq = '{0, 0, 0}; pq = '{0, 0, 0};
    m_cnt = 0; m_have = 0; m_pok = 0; m_pidx = 0; m_lock = 0; m_rate = 0;
    m_acc = 0; m_t256 = 0; m_t8 = 0; m_low = 0; m_st = 0; m_wk = 0;
  endtask

  task automatic model_edge(input int f, input int p, input int rst_ok);
    int rise, lvl, pu, flen, limit, loss, run, c, s;
    if (!rst_ok) begin model_clear(); return; end
    lvl = fq[1]; rise = (fq[1] == 1 && fq[2] == 0); pu = pq[1];
    flen = legal[m_rate];
    limit = m_lock ? flen + 2 : 514;
    loss = (m_low >= limit);
    run = m_lock && (m_st != 0);
    // ticks
    if (!run) begin m_acc = 0; m_t256 = 0; m_t8 = 0; end
    else if (rise) begin m_acc = 0; m_t256 = 1; m_t8 = 1; end
    else begin
      m_t8 = 0; s = m_acc + 32;
      if (s >= flen) begin m_acc = s - flen; m_t256 = 1; end
      else begin m_acc = s; m_t256 = 0; end
    end
    // power (uses the old low-run count)
    if (!pu) begin m_st = 0; m_wk = 0; end
    else if (m_st == 0) begin if (rise) begin m_st = 1; m_wk = 0; end end
    else if (m_st == 1) begin
      if (loss) m_st = 0;
      else if (rise) begin if (m_wk == 1) m_st = 2; else m_wk++; end
    end else if (loss) m_st = 0;
    // rate measurement
    if (rise && m_have) begin
      c = pick_rate(m_cnt);
      if (c < 0) m_lock = 0;
      else if (m_pok && m_pidx == c) begin m_lock = 1; m_rate = c; end
      m_pok = (c >= 0); m_pidx = (c < 0) ? 0 : c;
    end
    if (rise) m_cnt = 1; else if (m_cnt < 1023) m_cnt++;
    if (rise) m_have = 1;
    if (lvl) m_low = 0; else if (m_low < 1023) m_low++;
    void'(fq.pop_back()); fq.push_front(f);
    void'(pq.pop_back()); pq.push_front(p);
  endtask

  task automatic step(input logic f);
    fsync_in = f;
    @(posedge clk);
    model_edge(int'(fsync_in), int'(pwr_up_in), int'(rst_n));
    @(negedge clk);
    n_cyc++;
    if (tick_256k) seen_fast++;
    if (tick_8k)   seen_frame++;
    chk("R4 tick_256k vs model", int'(tick_256k), m_t256);
    chk("R5 tick_8k vs model",   int'(tick_8k),   m_t8);
    chk("R2 locked vs model",    int'(locked),    m_lock);
    chk("R1 rate_idx vs model",  int'(rate_idx),  m_rate);
    chk("R7 standby vs model",   int'(standby),   m_st == 0);
    chk("R9 tx_oe vs model",     int'(tx_oe),     m_st == 2);
    if (n_cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", n_cyc);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  task automatic frame(input int len);
    seen_fast = 0; seen_frame = 0;
    step(1'b1);
    for (int k = 1; k < len; k++) step(1'b0);
  endtask

  task automatic idle(input int len);
    seen_fast = 0; seen_frame = 0;
    for (int k = 0; k < len; k++) step(1'b0);
  endtask

  initial begin
    model_clear();
    rst_n = 1'b0; fsync_in = 1'b0; pwr_up_in = 1'b0;
    repeat (4) step(1'b0);
    rst_n = 1'b1;
    step(1'b0);
    chk("R1 reset locked", int'(locked), 0);
    chk("R8 reset standby", int'(standby), 1);
    chk("R9 reset tx_oe", int'(tx_oe), 0);

    pwr_up_in = 1'b1;
    // R10: first edge measures nothing, second cannot confirm
    frame(64); frame(64);
    chk("R10 no lock before third edge", int'(locked), 0);
    frame(64);
    chk("R2 lock after two agreeing frames", int'(locked), 1);
    chk("R1 rate index for 64", int'(rate_idx), 1);

    // every legal rate
    for (int r = 0; r < 7; r++) begin
      repeat (4) frame(legal[r]);
      frame(legal[r]);
      chk("R1 rate index", int'(rate_idx), r);
      chk("R2 locked at rate", int'(locked), 1);
      chk("R4 fast ticks per frame", seen_fast, 32);
      chk("R5 frame ticks per frame", seen_frame, 1);
      chk("R9 tx_oe running", int'(tx_oe), 1);
    end

    // near matches
    repeat (4) frame(191);
    chk("R1 191 maps to index 2", int'(rate_idx), 2);
    repeat (4) frame(194);
    chk("R1 194 maps to index 3", int'(rate_idx), 3);
    repeat (4) frame(257);
    chk("R1 257 maps to index 4", int'(rate_idx), 4);

    // single glitched frame
    repeat (3) frame(256);
    frame(320); frame(256);
    chk("R2 glitch keeps rate", int'(rate_idx), 4);
    chk("R2 glitch keeps lock", int'(locked), 1);

    // illegal length
    repeat (3) frame(256);
    frame(100); frame(256);
    chk("R3 illegal length unlocks", int'(locked), 0);
    chk("R3 illegal length holds rate", int'(rate_idx), 4);
    frame(256);
    chk("R6 no ticks while unlocked", seen_fast, 0);
    frame(256);
    chk("R2 relock after recovery", int'(locked), 1);

    // frame-sync loss
    repeat (3) frame(256);
    idle(400);
    chk("R7 loss enters standby", int'(standby), 1);
    chk("R7 loss drops tx_oe", int'(tx_oe), 0);
    idle(100);
    chk("R6 no ticks in standby", seen_fast, 0);
    frame(256); frame(256);
    chk("R9 tx_oe still low after two edges", int'(tx_oe), 0);
    frame(256);
    chk("R9 tx_oe high after third edge", int'(tx_oe), 1);

    // power-up input
    pwr_up_in = 1'b0;
    frame(256);
    chk("R8 power-down standby", int'(standby), 1);
    chk("R8 power-down tx_oe", int'(tx_oe), 0);
    frame(256);
    chk("R6 no ticks powered down", seen_fast, 0);
    pwr_up_in = 1'b1;
    frame(256); frame(256);
    chk("R9 wake holds tx_oe low", int'(tx_oe), 0);
    frame(256);
    chk("R9 wake enables tx_oe", int'(tx_oe), 1);
    frame(256);
    chk("R4 ticks resume", seen_fast, 32);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule